// File: doc/BRIEF.md
# Low-Storage Prefix Relocation with Reference/Change Tracking

This block turns a real address into an absolute address. It exchanges the 8 KB window at real address zero with the 8 KB window that starts at a programmable prefix. An address below 8 KB is moved up to the prefix location. An address inside the prefix window is moved down to absolute zero. Every other address leaves the block unchanged.

For each translated access, the block also records the access history of the 4 KB frame it lands in. It keeps one reference bit and one change bit for each frame, and it reports every update on a key write port so that an external storage-key array can mirror it.

Frames are updated only when the absolute address is within the configured memory size. The bits only accumulate: the read and write permission flags of an access are ORed into the stored value. The update is a registered read-modify-write. A request that follows straight after another request to the same frame takes the pending merged value, so no bit is lost. A separate clear port zeroes both bits of one chosen frame.

Top module: `prefix_remap_keys`

## Requirements
- R1: A request with real address below 0x2000 produces absolute address real + prefix.
- R2: A request with real address in [prefix, prefix + 0x2000) produces absolute address real − prefix. The upper limit of this range is exclusive.
- R3: Any other real address, including 0x2000 itself, appears unchanged as the absolute address.
- R4: The key write port is asserted only when the absolute address is less than or equal to mem_size. Equality counts as in range.
- R5: The key frame index equals the absolute address shifted right by 12 bits.
- R6: key_ref (bit 0 of a frame) is set by an access with rd=1. key_chg (bit 1) is set by an access with wr=1. Bits already set in a frame stay set in later updates to that frame.
- R7: Two requests on consecutive cycles to the same frame produce a second update that contains the bits of both requests.
- R8: A clear on clr_frame zeroes both bits of that frame, so the next access reports only its own bits.
- R9: A loaded prefix has its low 13 bits forced to zero.
- R10: Each result (abs_valid, abs_addr and the key port) appears exactly one clock after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request qualifier |
| req_addr | input | AW | Real address |
| req_rd | input | 1 | Access carries read permission |
| req_wr | input | 1 | Access carries write permission |
| pfx_load | input | 1 | Load the prefix register |
| pfx_data | input | AW | New prefix value |
| mem_size | input | AW | Highest absolute address that gets key updates |
| clr_en | input | 1 | Clear the bits of one frame |
| clr_frame | input | FIW | Frame to clear |
| abs_valid | output | 1 | Result valid |
| abs_addr | output | AW | Absolute address |
| key_we | output | 1 | Key update strobe |
| key_frame | output | FIW | Frame being updated |
| key_ref | output | 1 | Merged reference bit |
| key_chg | output | 1 | Merged change bit |

## Verification
The bench places real addresses in four places: inside the low window, inside the prefix window, just past the end of each window, and well away from both. This tells the upward swap, the downward swap and the pass-through apart, and shows that each window's upper limit is exclusive. Absolute addresses exactly at mem_size and one byte above it show whether the size comparison includes equality. Read-only, write-only and back-to-back accesses to the same frame show that the bits accumulate and that the forwarding path works. An access after a clear shows that the clear resets the frame. An unaligned prefix load shows that the low 13 bits are dropped.

// File: rtl/prefix_remap_keys.sv
module prefix_remap_keys #(
  parameter int AW      = 32,
  parameter int PAGE_SH = 12,
  parameter int WIN_SH  = 13,
  parameter int FRAMES  = 64,
  localparam int FIW    = $clog2(FRAMES)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic [AW-1:0]  req_addr,
  input  logic           req_rd,
  input  logic           req_wr,
  input  logic           pfx_load,
  input  logic [AW-1:0]  pfx_data,
  input  logic [AW-1:0]  mem_size,
  input  logic           clr_en,
  input  logic [FIW-1:0] clr_frame,
  output logic           abs_valid,
  output logic [AW-1:0]  abs_addr,
  output logic           key_we,
  output logic [FIW-1:0] key_frame,
  output logic           key_ref,
  output logic           key_chg
);

  localparam logic [AW:0] WIN = (AW+1)'(1) << WIN_SH;

  logic [AW-1:0]  pfx_q;
  logic [1:0]     keys [FRAMES];

  logic           in_low, in_pfx, hit_n;
  logic [AW-1:0]  abs_n;
  logic [FIW-1:0] frm_n;

  logic           v_q, hit_q, rd_q, wr_q;
  logic [AW-1:0]  abs_q;
  logic [1:0]     old_q, merged;

  assign in_low = {1'b0, req_addr} < WIN;
  assign in_pfx = ({1'b0, req_addr} >= {1'b0, pfx_q}) &&
                  ({1'b0, req_addr} < ({1'b0, pfx_q} + WIN));
  assign abs_n  = in_low ? req_addr + pfx_q :
                  in_pfx ? req_addr - pfx_q : req_addr;
  assign frm_n  = abs_n[PAGE_SH +: FIW];
  assign hit_n  = (abs_n <= mem_size) && (abs_n[AW-1:PAGE_SH+FIW] == '0);

  assign merged    = old_q | {wr_q, rd_q};
  assign abs_valid = v_q;
  assign abs_addr  = abs_q;
  assign key_we    = v_q && hit_q;
  assign key_frame = abs_q[PAGE_SH +: FIW];
  assign key_ref   = merged[0];
  assign key_chg   = merged[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pfx_q <= '0;
    else if (pfx_load) pfx_q <= {pfx_data[AW-1:WIN_SH], {WIN_SH{1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= 1'b0;
      hit_q <= 1'b0;
      rd_q  <= 1'b0;
      wr_q  <= 1'b0;
      abs_q <= '0;
      old_q <= '0;
    end else begin
      v_q   <= req_valid;
      hit_q <= req_valid && hit_n;
      rd_q  <= req_rd;
      wr_q  <= req_wr;
      abs_q <= abs_n;
      if (clr_en && clr_frame == frm_n) old_q <= 2'b00;
      else if (key_we && key_frame == frm_n) old_q <= merged;
      else old_q <= keys[frm_n];
    end
  end

  for (genvar f = 0; f < FRAMES; f++) begin : g_key
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) keys[f] <= 2'b00;
      else if (clr_en && clr_frame == FIW'(f)) keys[f] <= 2'b00;
      else if (key_we && key_frame == FIW'(f)) keys[f] <= merged;
    end
  end

  a_r1_low_window: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && {1'b0, req_addr} < WIN) |=> abs_addr == $past(req_addr) + $past(pfx_q));

  a_r4_size_limit: assert property (@(posedge clk) disable iff (!rst_n)
    key_we |-> abs_addr <= $past(mem_size));

  a_r5_frame_index: assert property (@(posedge clk) disable iff (!rst_n)
    key_we |-> key_frame == abs_addr[PAGE_SH +: FIW]);

  a_r6_sticky_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (key_we && $past(key_we) && key_frame == $past(key_frame) &&
     !$past(clr_en && clr_frame == key_frame))
    |-> (key_ref || !$past(key_ref)) && (key_chg || !$past(key_chg)));

  a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> abs_valid);

  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !abs_valid && !key_we);

endmodule

// File: tb/prefix_remap_keys_tb.sv
module prefix_remap_keys_tb;
  localparam int AW = 32, FIW = 6;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_rd = 0, req_wr = 0, pfx_load = 0, clr_en = 0;
  logic [AW-1:0] req_addr = '0, pfx_data = '0, mem_size = 32'h3F000;
  logic [FIW-1:0] clr_frame = '0;
  logic abs_valid, key_we, key_ref, key_chg;
  logic [AW-1:0] abs_addr;
  logic [FIW-1:0] key_frame;

  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  prefix_remap_keys u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_rd(req_rd), .req_wr(req_wr), .pfx_load(pfx_load), .pfx_data(pfx_data),
    .mem_size(mem_size), .clr_en(clr_en), .clr_frame(clr_frame),
    .abs_valid(abs_valid), .abs_addr(abs_addr), .key_we(key_we),
    .key_frame(key_frame), .key_ref(key_ref), .key_chg(key_chg));

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_out(input string req, input logic [AW-1:0] ea, input logic ew,
                           input logic er, input logic ec);
    chk({req, " valid"}, AW'(abs_valid), 1);
    chk({req, " abs"}, abs_addr, ea);
    chk({req, " we"}, AW'(key_we), AW'(ew));
    if (ew) begin
      chk({req, " frame"}, AW'(key_frame), AW'(ea[AW-1:12]));
      chk({req, " ref"}, AW'(key_ref), AW'(er));
      chk({req, " chg"}, AW'(key_chg), AW'(ec));
    end
  endtask

  task automatic access(input string req, input logic [AW-1:0] a, input logic rd, input logic wr,
                        input logic [AW-1:0] ea, input logic ew, input logic er, input logic ec);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_rd = rd; req_wr = wr;
    @(negedge clk);
    req_valid = 0; req_rd = 0; req_wr = 0;
    check_out(req, ea, ew, er, ec);
  endtask

  task automatic load_prefix(input logic [AW-1:0] p);
    @(negedge clk);
    pfx_load = 1; pfx_data = p;
    @(negedge clk);
    pfx_load = 0;
  endtask

  task automatic t_reset;
    chk("R10 reset valid", AW'(abs_valid), 0);
    chk("R10 reset we", AW'(key_we), 0);
  endtask

  task automatic t_windows;
    load_prefix(32'h10000);
    access("R1 low", 32'h1234, 1, 0, 32'h11234, 1, 1, 0);
    access("R1 low top", 32'h1FFF, 1, 0, 32'h11FFF, 1, 1, 0);
    access("R2 pfx", 32'h11ABC, 0, 1, 32'h1ABC, 1, 0, 1);
    access("R2 pfx base", 32'h10000, 1, 0, 32'h0, 1, 1, 0);
    access("R3 far", 32'h20000, 1, 0, 32'h20000, 1, 1, 0);
    access("R3 low edge", 32'h2000, 1, 0, 32'h2000, 1, 1, 0);
    access("R3 pfx edge", 32'h12000, 0, 1, 32'h12000, 1, 0, 1);
  endtask

  task automatic t_sticky;
    access("R6 sticky", 32'h20010, 0, 1, 32'h20010, 1, 1, 1);
    access("R5 frame", 32'h25FFF, 0, 0, 32'h25FFF, 1, 0, 0);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    req_valid = 1; req_addr = 32'h30000; req_rd = 1; req_wr = 0;
    @(negedge clk);
    req_addr = 32'h30800; req_rd = 0; req_wr = 1;
    check_out("R7 first", 32'h30000, 1, 1, 0);
    @(negedge clk);
    req_valid = 0; req_wr = 0;
    check_out("R7 second", 32'h30800, 1, 1, 1);
  endtask

  task automatic t_size;
    access("R4 above", 32'h3F001, 0, 1, 32'h3F001, 0, 0, 0);
    access("R4 equal", 32'h3F000, 1, 0, 32'h3F000, 1, 1, 0);
  endtask

  task automatic t_clear;
    @(negedge clk);
    clr_en = 1; clr_frame = 6'h20;
    @(negedge clk);
    clr_en = 0;
    access("R8 clear", 32'h20000, 1, 0, 32'h20000, 1, 1, 0);
  endtask

  task automatic t_align;
    load_prefix(32'h18FFF);
    access("R9 align", 32'h0, 0, 0, 32'h18000, 1, 0, 0);
  endtask

  initial begin
    #1;
    t_reset;
    repeat (2) @(negedge clk);
    rst_n = 1;
    t_windows;
    t_sticky;
    t_back_to_back;
    t_size;
    t_clear;
    t_align;
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    checks++; failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule